// File: doc/BRIEF.md
# Serial Converter Frame Reader

This block is the host-side master for a slow delta-sigma converter that sends a 32-bit result frame over a three-wire serial link. On a start request it lowers chip select with the serial clock held low, which puts the converter in externally clocked mode. It then watches the converter's data line. That line stays high while a conversion is running and drops low once a result is ready. Conversion takes well over a hundred milliseconds, so the wait is bounded only by a large timeout counter. When the line goes low, the reader issues exactly 32 clock pulses with fixed, parameterised high and low phases. It samples the data line at every rising edge, then releases chip select. Releasing chip select also starts the converter's next conversion.

The captured frame leaves the block on a parallel output with a one-cycle valid strobe. This output has no ready input and cannot be back-pressured. The consumer must take the word in the cycle the strobe is high, and the next frame cannot arrive sooner than a full read later. An abort request raises chip select at once and throws the partial frame away. A poll that outlasts the timeout sets a sticky error flag, which is cleared by the next start. The meaning of the bits inside the frame is left to the consumer.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the valid strobe is low and the timeout flag is low.
- R2: After a start, chip select goes low. No serial clock edge is issued while the data line is high; the first rising edge follows only after the line has been seen low.
- R3: The serial clock is low whenever chip select is high, including at the chip-select falling edge. Chip select is low for at least 2*HALF_DIV system cycles before the first rising edge.
- R4: Every high phase and every low phase between rising edges of a read lasts exactly HALF_DIV system cycles. The default of 32 gives 256 ns at 125 MHz, which keeps the clock at or below 2 MHz.
- R5: A completed read issues exactly FRAME_BITS rising edges and samples the data line at each one. The bit taken at the first edge lands in frame_o[FRAME_BITS-1] (MSB first), and the bit taken at the last edge lands in frame_o[0].
- R6: frame_valid_o is high for exactly one cycle per completed read. It is high in the same cycle that chip select rises after the last falling edge, and frame_o holds the captured word in that cycle.
- R7: An abort during a read raises chip select and forces the clock low on the next cycle, and no valid strobe is produced for that read. An abort that falls on the cycle the read would complete takes priority over completion.
- R8: If the data line stays high for TIMEOUT_CYCLES cycles of polling, chip select is released with no clock edges and timeout_err_o is set. The flag stays set until the next accepted start clears it.
- R9: A start request during a read is ignored: the read continues with 32 edges and yields one valid frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| start_i | input | 1 | Request one read |
| abort_i | input | 1 | Abandon the read in progress |
| cs_n_o | output | 1 | Converter chip select, active low |
| sclk_o | output | 1 | Serial clock to the converter |
| sdi_i | input | 1 | Serial data from the converter |
| frame_o | output | FRAME_BITS | Captured frame, first bit in the MSB |
| frame_valid_o | output | 1 | One-cycle strobe qualifying frame_o |
| timeout_err_o | output | 1 | Sticky poll-timeout flag |

## Verification
Completion and abort can land in the same system cycle. This happens when the abort request arrives exactly on the last cycle of the 32nd high phase. The bench provokes this by counting from the observed 32nd rising edge to the cycle before the final falling edge, and pulsing abort in that one cycle only. The result is judged at the ports: chip select must rise, and the valid strobe must never appear for that read. A second meeting point, a start request in the middle of a read, is judged by the edge count and by a single correct frame.

// File: rtl/adcr_pkg.sv
package adcr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_POLL,
    ST_HIGH,
    ST_LOW
  } rd_state_e;
endpackage

// File: rtl/adcr_tick.sv
// Run-time interval counter: expired pulses on the LIMIT-th running cycle.
module adcr_tick #(
  parameter int unsigned LIMIT = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic clr_i,
  output logic expired_o
);
  localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] END_CNT = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == END_CNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i || expired_o)  cnt_q <= '0;
    else if (run_i)               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adcr_capture.sv
// Shift register for incoming bits plus the registered frame/valid pair.
module adcr_capture #(
  parameter int unsigned BITS = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            shift_i,
  input  logic            bit_i,
  input  logic            publish_i,
  output logic [BITS-1:0] frame_o,
  output logic            valid_o
);
  logic [BITS-1:0] shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shreg_q <= '0;
    else if (shift_i) shreg_q <= {shreg_q[BITS-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= publish_i;
      if (publish_i) frame_o <= shreg_q;
    end
  end
endmodule

// File: rtl/adcr_ctrl.sv
// Read sequencer: setup, ready poll, clock pulse train, release.
module adcr_ctrl
  import adcr_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic sdi_s_i,
  input  logic phase_done_i,
  input  logic poll_expired_i,
  output logic cs_n_o,
  output logic sclk_o,
  output logic timeout_err_o,
  output logic phase_run_o,
  output logic phase_clr_o,
  output logic poll_run_o,
  output logic poll_clr_o,
  output logic shift_o,
  output logic publish_o
);
  localparam int unsigned BCW = $clog2(FRAME_BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

  rd_state_e      state_q;
  logic           setup_half_q;
  logic [BCW-1:0] bit_q;

  always_comb begin
    phase_run_o = (state_q == ST_SETUP) || (state_q == ST_HIGH) || (state_q == ST_LOW);
    phase_clr_o = !phase_run_o;
    poll_run_o  = (state_q == ST_POLL);
    poll_clr_o  = !poll_run_o;
    shift_o     = !abort_i && (((state_q == ST_POLL) && !sdi_s_i) ||
                               ((state_q == ST_LOW) && phase_done_i));
    publish_o   = !abort_i && (state_q == ST_HIGH) && phase_done_i && (bit_q == LAST_BIT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q       <= ST_IDLE;
      cs_n_o        <= 1'b1;
      sclk_o        <= 1'b0;
      timeout_err_o <= 1'b0;
      setup_half_q  <= 1'b0;
      bit_q         <= '0;
    end else if (abort_i && (state_q != ST_IDLE)) begin
      state_q <= ST_IDLE;
      cs_n_o  <= 1'b1;
      sclk_o  <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i && !abort_i) begin
          state_q       <= ST_SETUP;
          cs_n_o        <= 1'b0;
          timeout_err_o <= 1'b0;
          setup_half_q  <= 1'b0;
        end
        ST_SETUP: if (phase_done_i) begin
          if (setup_half_q) state_q <= ST_POLL;
          setup_half_q <= 1'b1;
        end
        ST_POLL: begin
          if (!sdi_s_i) begin
            state_q <= ST_HIGH;
            sclk_o  <= 1'b1;
            bit_q   <= '0;
          end else if (poll_expired_i) begin
            state_q       <= ST_IDLE;
            cs_n_o        <= 1'b1;
            timeout_err_o <= 1'b1;
          end
        end
        ST_HIGH: if (phase_done_i) begin
          sclk_o <= 1'b0;
          if (bit_q == LAST_BIT) begin
            state_q <= ST_IDLE;
            cs_n_o  <= 1'b1;
          end else begin
            state_q <= ST_LOW;
            bit_q   <= bit_q + 1'b1;
          end
        end
        ST_LOW: if (phase_done_i) begin
          state_q <= ST_HIGH;
          sclk_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int unsigned HALF_DIV       = 32,
  parameter int unsigned FRAME_BITS     = 32,
  parameter int unsigned TIMEOUT_CYCLES = 25_000_000
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  abort_i,
  output logic                  cs_n_o,
  output logic                  sclk_o,
  input  logic                  sdi_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  frame_valid_o,
  output logic                  timeout_err_o
);
  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] sdi_sync_q;
  logic sdi_s;
  logic phase_run, phase_clr, phase_done;
  logic poll_run, poll_clr, poll_expired;
  logic shift_en, publish;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdi_sync_q <= '1;
    else         sdi_sync_q <= {sdi_sync_q[SYNC_STAGES-2:0], sdi_i};
  end
  assign sdi_s = sdi_sync_q[SYNC_STAGES-1];

  adcr_tick #(.LIMIT(HALF_DIV)) phase_tick_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(phase_run), .clr_i(phase_clr),
    .expired_o(phase_done)
  );

  adcr_tick #(.LIMIT(TIMEOUT_CYCLES)) poll_tick_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(poll_run), .clr_i(poll_clr),
    .expired_o(poll_expired)
  );

  adcr_ctrl #(.FRAME_BITS(FRAME_BITS)) ctrl_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .sdi_s_i(sdi_s), .phase_done_i(phase_done), .poll_expired_i(poll_expired),
    .cs_n_o(cs_n_o), .sclk_o(sclk_o), .timeout_err_o(timeout_err_o),
    .phase_run_o(phase_run), .phase_clr_o(phase_clr),
    .poll_run_o(poll_run), .poll_clr_o(poll_clr),
    .shift_o(shift_en), .publish_o(publish)
  );

  adcr_capture #(.BITS(FRAME_BITS)) capture_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(shift_en), .bit_i(sdi_s),
    .publish_i(publish), .frame_o(frame_o), .valid_o(frame_valid_o)
  );
endmodule

// File: rtl/adcr_checker.sv
module adcr_checker #(
  parameter int unsigned HALF_DIV   = 32,
  parameter int unsigned FRAME_BITS = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  abort_i,
  input logic                  cs_n_o,
  input logic                  sclk_o,
  input logic [FRAME_BITS-1:0] frame_o,
  input logic                  frame_valid_o,
  input logic                  timeout_err_o
);
  int unsigned hi_len;
  int unsigned rise_cnt;
  logic        sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len   <= 0;
      rise_cnt <= 0;
      sclk_q   <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      hi_len <= sclk_o ? hi_len + 1 : 0;
      if (cs_n_o)                 rise_cnt <= 0;
      else if (sclk_o && !sclk_q) rise_cnt <= rise_cnt + 1;
    end
  end

  AST_IDLE_CLOCK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> !sclk_o); // R3
  AST_HIGH_PHASE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(sclk_o) && (!cs_n_o || frame_valid_o)) |-> (hi_len == HALF_DIV)); // R4
  AST_FRAME_EDGE_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> (rise_cnt == FRAME_BITS)); // R5
  AST_VALID_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |=> !frame_valid_o); // R6
  AST_VALID_AT_CS_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_valid_o |-> $rose(cs_n_o)); // R6
  AST_ABORT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && !cs_n_o) |=> (cs_n_o && !sclk_o && !frame_valid_o)); // R7
  AST_TIMEOUT_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_err_o) |-> (cs_n_o && !sclk_o && !frame_valid_o)); // R8
endmodule

bind adc_frame_reader adcr_checker #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .abort_i(abort_i), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .frame_o(frame_o), .frame_valid_o(frame_valid_o),
  .timeout_err_o(timeout_err_o)
);

// File: tb/adc_frame_reader_tb_top.sv
`timescale 1ns/1ps
module adc_frame_reader_tb_top;
  localparam int HALF_DIV = 32;
  localparam int FRAME_BITS = 32;
  localparam int TIMEOUT = 3000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic abort = 1'b0;
  logic sdi = 1'b1;
  logic cs_n, sclk, valid, err;
  logic [FRAME_BITS-1:0] frame;

  int n_checks = 0;
  int n_fails = 0;

  always #4 clk = ~clk;

  adc_frame_reader #(.HALF_DIV(HALF_DIV), .FRAME_BITS(FRAME_BITS), .TIMEOUT_CYCLES(TIMEOUT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .cs_n_o(cs_n), .sclk_o(sclk), .sdi_i(sdi), .frame_o(frame),
    .frame_valid_o(valid), .timeout_err_o(err)
  );

  // converter model and line monitor, both at the falling system-clock edge
  logic [FRAME_BITS-1:0] slv_frame = '0;
  int  slv_delay = 0;
  int  slv_busy = 0;
  int  slv_idx = 0;
  bit  slv_ready = 0;
  int  rises = 0, early_rises = 0, setup_len = 0, run = 0;
  int  hi_min = 0, hi_max = 0, lo_min = 0, lo_max = 0;
  int  valid_pulses = 0;
  bit  valid_width_bad = 0, valid_cs_bad = 0, cs_fall_clk_bad = 0;
  logic [FRAME_BITS-1:0] last_frame = '0;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, prev_valid = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_cs && !cs_n) begin
        rises = 0; early_rises = 0; setup_len = 0; run = 0;
        hi_min = 1 << 30; hi_max = 0; lo_min = 1 << 30; lo_max = 0;
        slv_busy = slv_delay; slv_idx = FRAME_BITS - 1; slv_ready = 0; sdi = 1'b1;
        if (sclk) cs_fall_clk_bad = 1;
      end
      if (!cs_n) begin
        if (!slv_ready) begin
          if (slv_busy == 0) begin slv_ready = 1; sdi = slv_frame[FRAME_BITS-1]; end
          else slv_busy--;
        end
        if (sclk == prev_sclk) run++;
        else begin
          if (prev_sclk) begin
            if (run < hi_min) hi_min = run;
            if (run > hi_max) hi_max = run;
          end else if (rises > 0) begin
            if (run < lo_min) lo_min = run;
            if (run > lo_max) lo_max = run;
          end
          run = 1;
        end
        if (sclk && !prev_sclk) begin
          rises++;
          if (!slv_ready) early_rises++;
        end
        if (rises == 0 && !sclk) setup_len++;
        if (!sclk && prev_sclk && slv_idx > 0) begin
          slv_idx--;
          sdi = slv_frame[slv_idx];
        end
      end else begin
        sdi = 1'b1;
      end
      if (valid) begin
        valid_pulses++;
        last_frame = frame;
        if (prev_valid) valid_width_bad = 1;
        if (!(cs_n && !prev_cs)) valid_cs_bad = 1;
      end
    end
    prev_cs = cs_n; prev_sclk = sclk; prev_valid = valid;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic pulse_abort();
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
  endtask

  task automatic wait_release(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(posedge clk);
      if (cs_n) break;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic wait_rises(input int n);
    for (int i = 0; i < 20000; i++) begin
      if (rises >= n) break;
      @(posedge clk);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    check(cs_n == 1'b1, "R1", "chip select after reset", cs_n, 1);
    check(sclk == 1'b0, "R1", "clock after reset", sclk, 0);
    check(valid == 1'b0, "R1", "valid after reset", valid, 0);
    check(err == 1'b0, "R1", "timeout flag after reset", err, 0);
  endtask

  task automatic t_frame(input logic [FRAME_BITS-1:0] word, input int delay);
    int vp;
    slv_frame = word; slv_delay = delay; vp = valid_pulses;
    pulse_start();
    repeat (2) @(posedge clk);
    check(cs_n == 1'b0, "R2", "chip select low after start", cs_n, 0);
    wait_release(10000);
    check(valid_pulses == vp + 1, "R6", "valid pulses per read", valid_pulses - vp, 1);
    check(last_frame == word, "R5", "captured frame", last_frame, word);
    check(rises == FRAME_BITS, "R5", "rising edges per read", rises, FRAME_BITS);
    check(early_rises == 0, "R2", "edges before ready", early_rises, 0);
    check(setup_len >= 2 * HALF_DIV, "R3", "cs-to-first-edge cycles", setup_len, 2 * HALF_DIV);
    check(hi_min == HALF_DIV && hi_max == HALF_DIV, "R4", "high phase width", hi_max, HALF_DIV);
    check(lo_min == HALF_DIV && lo_max == HALF_DIV, "R4", "low phase width", lo_max, HALF_DIV);
    check(!valid_width_bad && !valid_cs_bad, "R6", "valid single and at cs rise",
          {valid_width_bad, valid_cs_bad}, 0);
    check(!cs_fall_clk_bad, "R3", "clock low at cs fall", cs_fall_clk_bad, 0);
  endtask

  task automatic t_poll_hold();
    slv_frame = 32'h1357_9BDF; slv_delay = 900;
    pulse_start();
    repeat (700) @(posedge clk);
    check(sclk == 1'b0 && rises == 0, "R2", "no clock while line high", rises, 0);
    check(cs_n == 1'b0, "R2", "chip select held during poll", cs_n, 0);
    wait_release(10000);
    check(last_frame == 32'h1357_9BDF, "R2", "frame after long poll", last_frame, 32'h1357_9BDF);
  endtask

  task automatic t_abort_mid();
    int vp;
    slv_frame = 32'h0F0F_3C3C; slv_delay = 20; vp = valid_pulses;
    pulse_start();
    wait_rises(10);
    pulse_abort();
    @(negedge clk);
    check(cs_n == 1'b1 && sclk == 1'b0, "R7", "release after abort", {cs_n, sclk}, 2'b10);
    repeat (3000) @(posedge clk);
    check(valid_pulses == vp, "R7", "valid after abort", valid_pulses - vp, 0);
    check(rises <= 11, "R7", "edges after abort", rises, 10);
  endtask

  task automatic t_abort_at_end();
    int vp;
    slv_frame = 32'h2468_ACE0; slv_delay = 10; vp = valid_pulses;
    pulse_start();
    wait_rises(FRAME_BITS);
    repeat (HALF_DIV - 2) @(posedge clk);
    @(negedge clk) abort = 1'b1;
    @(negedge clk) abort = 1'b0;
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R7", "cs after abort on last cycle", cs_n, 1);
    check(valid_pulses == vp, "R7", "abort beats completion", valid_pulses - vp, 0);
  endtask

  task automatic t_start_while_busy();
    int vp;
    slv_frame = 32'h5A5A_0FF1; slv_delay = 30; vp = valid_pulses;
    pulse_start();
    wait_rises(5);
    pulse_start();
    wait_release(10000);
    check(valid_pulses == vp + 1, "R9", "one frame despite extra start", valid_pulses - vp, 1);
    check(rises == FRAME_BITS, "R9", "edge count despite extra start", rises, FRAME_BITS);
    check(last_frame == 32'h5A5A_0FF1, "R9", "frame despite extra start", last_frame, 32'h5A5A_0FF1);
  endtask

  task automatic t_timeout();
    int vp;
    slv_delay = 1_000_000; vp = valid_pulses;
    pulse_start();
    for (int i = 0; i < TIMEOUT + 500; i++) begin
      @(posedge clk);
      if (err) break;
    end
    @(negedge clk);
    check(err == 1'b1, "R8", "timeout flag", err, 1);
    check(cs_n == 1'b1, "R8", "cs released on timeout", cs_n, 1);
    check(rises == 0 && valid_pulses == vp, "R8", "no edges or frame on timeout", rises, 0);
    repeat (50) @(negedge clk);
    check(err == 1'b1, "R8", "timeout flag sticky", err, 1);
    t_frame(32'h0000_0001, 5);
    check(err == 1'b0, "R8", "flag cleared by next start", err, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hung, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_frame(32'h3A5C_96E1, 40);
    t_frame(32'h7FFF_FFFF, 0);
    t_frame(32'h0000_0000, 3);
    t_poll_hold();
    t_abort_mid();
    t_frame(32'h6B1D_0A55, 12);
    t_abort_at_end();
    t_start_while_busy();
    t_timeout();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule